// File: doc/BRIEF.md
# DDR bank auto-precharge tracker

This block follows the command-level state of a set of DDR SDRAM banks, with most of its logic spent on what happens after a read that carries an automatic precharge. It receives one decoded command per clock (no-op, activate, read, read with auto precharge, precharge) together with a bank number. Every command is judged against the addressed bank's present state and timers, and the verdict is reported on the next clock as a single legal flag. A command judged illegal is dropped and leaves every bank exactly as it was.

Each bank keeps three counters: clocks since its activate (saturating at the row-active minimum), clocks since its auto-precharge read (saturating just past half the burst length), and clocks spent in precharge. The internal precharge starts half a burst after the auto-precharge read, or later if the row-active minimum has not yet run out, and the bank returns to idle once the precharge time has passed. A controller model or a protocol monitor can use the flag and the per-bank state vector to screen a command stream. Data-path timing, refresh and writes are not modelled.

Top module: `ddr_ap_tracker`

## Requirements
- R1: After reset every bank reports idle on `state_o` (two bits per bank, bank b at bits 2b+1:2b; 0 = idle, 1 = active, 2 = precharging, 3 never occurs) and `legal_o` is 1. A command presented in cycle n is reflected on `legal_o` and `state_o` in cycle n+1.
- R2: An activate (code 1) is legal only to an idle bank, which then reports active; an activate to a bank that is active or precharging is illegal.
- R3: A read (code 2) or auto-precharge read (code 3) to an idle bank is illegal. A plain read to an active bank is legal and the bank stays active for any number of cycles.
- R4: With the activate in cycle a and an accepted auto-precharge read in cycle r, the internal precharge begins in cycle p = r + BURST_LEN/2 when p is at least a + TRAS_CLK; the bank reports precharging from cycle p+1, reports idle in cycle p + TRP_CLK, and an activate to it is illegal before that cycle and legal in it.
- R5: When r + BURST_LEN/2 is earlier than a + TRAS_CLK, the start of the internal precharge is put off to cycle p = a + TRAS_CLK, with the rest of R4 following from that p.
- R6: In cycles r+1 through r + BURST_LEN/2 a read or auto-precharge read to the same bank is illegal; from r + BURST_LEN/2 + 1 until the bank is idle it is legal and changes nothing.
- R7: A precharge (code 4) to an idle bank is legal and changes nothing. To an active bank, or to a bank within cycles r+1 through r + BURST_LEN/2 of its auto-precharge read, it is legal only once TRAS_CLK cycles have passed since the activate, and it starts the precharge in that cycle. After that window, or while the bank is precharging, it is illegal.
- R8: A command to one bank is judged only by that bank's state; with the default parameters, reads, auto-precharge reads and precharges to another active bank and an activate to another idle bank are legal in the three cycles after an auto-precharge read.
- R9: A no-op (code 0) and the unused codes 5, 6 and 7 are always legal and change no bank state.
- R10: A command flagged illegal changes no bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code for this cycle |
| bank_i | input | BANK_W | Bank addressed by the command |
| legal_o | output | 1 | Verdict on the previous cycle's command |
| state_o | output | 2*NUM_BANKS | Two-bit state code per bank |

## Verification
The hardest situation to reach is a deferred precharge start, where the half-burst point comes before the row-active minimum has elapsed, since the bank then looks the same at its outputs until the late start shows up. The stimulus issues the auto-precharge read one cycle after the activate, tries an early precharge that must be refused, and samples the state code cycle by cycle so that a start one cycle early or late is caught. The legality grid is reached by repeating one fixed preamble (activate, wait, auto-precharge read) and placing a single probe command one, two or three cycles later, so that no probe disturbs another.

// File: rtl/ddr_aptrk_pkg.sv
package ddr_aptrk_pkg;

  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_ACT  = 3'd1;
  localparam logic [2:0] CMD_RD   = 3'd2;
  localparam logic [2:0] CMD_RDAP = 3'd3;
  localparam logic [2:0] CMD_PRE  = 3'd4;

  localparam logic [1:0] VIEW_IDLE = 2'd0;
  localparam logic [1:0] VIEW_ACT  = 2'd1;
  localparam logic [1:0] VIEW_PRC  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_APW,
    ST_PRC
  } bank_st_e;

endpackage

// File: rtl/ddr_aptrk_cmd_dec.sv
module ddr_aptrk_cmd_dec
  import ddr_aptrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [2:0]          cmd_i,
  input  logic [BANK_W-1:0]   bank_i,
  output logic [NUM_BANKS-1:0] hit_o,
  output logic                is_act_o,
  output logic                is_rd_o,
  output logic                is_rdap_o,
  output logic                is_pre_o
);

  logic any_cmd;

  always_comb begin
    is_act_o  = (cmd_i == CMD_ACT);
    is_rd_o   = (cmd_i == CMD_RD);
    is_rdap_o = (cmd_i == CMD_RDAP);
    is_pre_o  = (cmd_i == CMD_PRE);
    any_cmd   = is_act_o | is_rd_o | is_rdap_o | is_pre_o;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
    assign hit_o[g] = any_cmd && (bank_i == BANK_W'(g));
  end

endmodule

// File: rtl/ddr_aptrk_bank.sv
module ddr_aptrk_bank
  import ddr_aptrk_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int TRAS_CLK  = 4,
  parameter int TRP_CLK   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       is_act,
  input  logic       is_rd,
  input  logic       is_rdap,
  input  logic       is_pre,
  output logic       legal_o,
  output logic [1:0] view_o
);

  localparam int HALF = BURST_LEN / 2;
  localparam int TW   = $clog2(TRAS_CLK + 1);
  localparam int BW   = $clog2(HALF + 2);
  localparam int PW   = (TRP_CLK > 2) ? $clog2(TRP_CLK) : 1;
  localparam logic [TW-1:0] TRAS_C   = TW'(TRAS_CLK);
  localparam logic [BW-1:0] HALF_C   = BW'(HALF);
  localparam logic [BW-1:0] HALF_P1  = BW'(HALF + 1);
  localparam logic [PW-1:0] TRP_LAST = PW'(TRP_CLK - 1);

  bank_st_e        st_q;
  logic [TW-1:0]   tras_q;
  logic [BW-1:0]   burst_q;
  logic [PW-1:0]   trp_q;
  logic            tras_met;
  logic            burst_end;
  logic            burst_done;
  logic            legal_c;
  logic            accept;
  logic            auto_start;

  always_comb begin
    tras_met   = (tras_q >= TRAS_C);
    burst_end  = (burst_q >= HALF_C);
    burst_done = (burst_q > HALF_C);
    auto_start = (st_q == ST_APW) && burst_end && tras_met;
  end

  always_comb begin
    legal_c = 1'b1;
    if (is_act) begin
      legal_c = (st_q == ST_IDLE);
    end else if (is_rd || is_rdap) begin
      legal_c = (st_q == ST_OPEN) || (st_q == ST_PRC) ||
                ((st_q == ST_APW) && burst_done);
    end else if (is_pre) begin
      legal_c = (st_q == ST_IDLE) ||
                (((st_q == ST_OPEN) || ((st_q == ST_APW) && !burst_done)) && tras_met);
    end
  end

  assign legal_o = legal_c;
  assign accept  = hit && legal_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      tras_q  <= '0;
      burst_q <= '0;
      trp_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept && is_act) begin
            st_q   <= ST_OPEN;
            tras_q <= TW'(1);
          end
        end
        ST_OPEN: begin
          if (tras_q < TRAS_C) tras_q <= tras_q + TW'(1);
          if (accept && is_rdap) begin
            st_q    <= ST_APW;
            burst_q <= BW'(1);
          end else if (accept && is_pre) begin
            st_q  <= ST_PRC;
            trp_q <= PW'(1);
          end
        end
        ST_APW: begin
          if (tras_q < TRAS_C) tras_q <= tras_q + TW'(1);
          if (burst_q < HALF_P1) burst_q <= burst_q + BW'(1);
          if ((accept && is_pre) || auto_start) begin
            st_q  <= ST_PRC;
            trp_q <= PW'(1);
          end
        end
        default: begin
          if (trp_q >= TRP_LAST) begin
            st_q    <= ST_IDLE;
            tras_q  <= '0;
            burst_q <= '0;
            trp_q   <= '0;
          end else begin
            trp_q <= trp_q + PW'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_IDLE: view_o = VIEW_IDLE;
      ST_PRC:  view_o = VIEW_PRC;
      default: view_o = VIEW_ACT;
    endcase
  end

  // Checker counter: consecutive cycles spent in the precharge state.
  logic [PW:0] prc_len_q;
  always_ff @(posedge clk) begin
    if (rst) prc_len_q <= '0;
    else if (st_q == ST_PRC) prc_len_q <= prc_len_q + (PW+1)'(1);
    else prc_len_q <= '0;
  end

  p_idle_open_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && hit && is_act) |=> (st_q == ST_OPEN));

  p_start_needs_tras_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PRC && $past(st_q) != ST_PRC) |-> $past(tras_met));

  p_prc_len_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && $past(st_q) == ST_PRC) |-> (prc_len_q == (PW+1)'(TRP_CLK - 1)));

  p_illegal_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (hit && !legal_c && (st_q == ST_IDLE || st_q == ST_OPEN)) |=> $stable(st_q));

endmodule

// File: rtl/ddr_aptrk_resp.sv
module ddr_aptrk_resp #(
  parameter int NUM_BANKS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_BANKS-1:0]   hit_i,
  input  logic [NUM_BANKS-1:0]   bank_legal_i,
  output logic                   legal_o
);

  logic verdict;

  assign verdict = &(~hit_i | bank_legal_i);

  always_ff @(posedge clk) begin
    if (rst) legal_o <= 1'b1;
    else     legal_o <= verdict;
  end

endmodule

// File: rtl/ddr_ap_tracker.sv
module ddr_ap_tracker
  import ddr_aptrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int TRAS_CLK  = 4,
  parameter int TRP_CLK   = 3,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               cmd_i,
  input  logic [BANK_W-1:0]        bank_i,
  output logic                     legal_o,
  output logic [2*NUM_BANKS-1:0]   state_o
);

  logic [NUM_BANKS-1:0] hit;
  logic [NUM_BANKS-1:0] bank_legal;
  logic is_act, is_rd, is_rdap, is_pre;

  ddr_aptrk_cmd_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cmd_i     (cmd_i),
    .bank_i    (bank_i),
    .hit_o     (hit),
    .is_act_o  (is_act),
    .is_rd_o   (is_rd),
    .is_rdap_o (is_rdap),
    .is_pre_o  (is_pre)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    ddr_aptrk_bank #(
      .BURST_LEN (BURST_LEN),
      .TRAS_CLK  (TRAS_CLK),
      .TRP_CLK   (TRP_CLK)
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit[g]),
      .is_act  (is_act),
      .is_rd   (is_rd),
      .is_rdap (is_rdap),
      .is_pre  (is_pre),
      .legal_o (bank_legal[g]),
      .view_o  (state_o[2*g +: 2])
    );

    p_state_code_r1: assert property (@(posedge clk) disable iff (rst)
      state_o[2*g +: 2] != 2'b11);
  end

  ddr_aptrk_resp #(.NUM_BANKS(NUM_BANKS)) u_resp (
    .clk          (clk),
    .rst          (rst),
    .hit_i        (hit),
    .bank_legal_i (bank_legal),
    .legal_o      (legal_o)
  );

  p_nop_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_NOP) |=> legal_o);

  p_rd_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == CMD_RD && state_o[2*bank_i +: 2] == VIEW_IDLE) |=> !legal_o);

  p_rd_after_ap_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cmd_i) == CMD_RDAP && legal_o &&
     (cmd_i == CMD_RD || cmd_i == CMD_RDAP) && bank_i == $past(bank_i)) |=> !legal_o);

endmodule

// File: tb/ddr_ap_tracker_test.sv
module ddr_ap_tracker_test;
  import ddr_aptrk_pkg::*;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cmd_i = CMD_NOP;
  logic [1:0] bank_i = 2'd0;
  logic       legal_o;
  logic [7:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    q_el[$];
  int    q_sb[$];
  int    q_es[$];
  string q_tag[$];

  always #(CLK_P/2) clk = ~clk;

  ddr_ap_tracker uut (
    .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i),
    .legal_o(legal_o), .state_o(state_o)
  );

  // Driver: el = expected legal (-1 = not checked); es = expected state of bank sb (-1 = none)
  task automatic issue(input logic [2:0] c, input int b, input int el,
                       input int sb, input int es, input string tag);
    @(negedge clk);
    cmd_i  = c;
    bank_i = b[1:0];
    q_el.push_back(el);
    q_sb.push_back(sb);
    q_es.push_back(es);
    q_tag.push_back(tag);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) issue(CMD_NOP, 0, 1, 0, -1, "R9 nop");
  endtask

  // Monitor: outputs for the command of the previous cycle
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q_el.size() > 0) begin
        int el, sb, es;
        string tag;
        logic [1:0] st;
        el = q_el.pop_front();
        sb = q_sb.pop_front();
        es = q_es.pop_front();
        tag = q_tag.pop_front();
        if (el >= 0) begin
          checks++;
          if (legal_o !== el[0]) begin
            errors++;
            $display("FAIL %s: legal_o=%0b expected %0b", tag, legal_o, el[0]);
          end
        end
        if (es >= 0) begin
          checks++;
          st = state_o[2*sb +: 2];
          if (st !== es[1:0]) begin
            errors++;
            $display("FAIL %s: bank%0d state=%0d expected %0d", tag, sb, st, es);
          end
        end
      end
    end
  end

  task automatic settle_all_idle(input string tag);
    nops(6);
    issue(CMD_PRE, 0, -1, 0, -1, tag);
    issue(CMD_PRE, 1, -1, 0, -1, tag);
    issue(CMD_PRE, 2, -1, 0, -1, tag);
    nops(4);
    for (int b = 0; b < 4; b++) issue(CMD_NOP, 0, 1, b, 0, tag);
  endtask

  // Preamble: ACT b1, NOP, ACT b0 (cycle 0), NOP, NOP, RDAP b0 (cycle 3); probe at cycle 3+k
  task automatic run_grid(input logic [2:0] c, input int b, input int k,
                          input int el, input string tag);
    issue(CMD_ACT, 1, 1, 1, VIEW_ACT, "R2 grid preamble");
    nops(1);
    issue(CMD_ACT, 0, 1, 0, VIEW_ACT, "R2 grid preamble");
    nops(2);
    issue(CMD_RDAP, 0, 1, 0, VIEW_ACT, "R4 grid preamble");
    nops(k - 1);
    issue(c, b, el, 0, -1, tag);
    settle_all_idle("R4 grid cleanup idle");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int b = 0; b < 4; b++) issue(CMD_NOP, 0, 1, b, VIEW_IDLE, "R1 reset idle");

    // R3 / R9 / R7 / R2 on an idle bank
    issue(CMD_RD,   3, 0, 3, VIEW_IDLE, "R3 read to idle");
    issue(CMD_RDAP, 3, 0, 3, VIEW_IDLE, "R3 ap-read to idle");
    issue(3'd5, 3, 1, 3, VIEW_IDLE, "R9 code 5");
    issue(3'd6, 3, 1, 3, VIEW_IDLE, "R9 code 6");
    issue(CMD_PRE, 3, 1, 3, VIEW_IDLE, "R7 precharge idle");
    issue(CMD_ACT, 3, 1, 3, VIEW_ACT, "R2 activate idle");          // cycle 0
    issue(CMD_ACT, 3, 0, 3, VIEW_ACT, "R2 activate open");          // c1
    issue(CMD_PRE, 3, 0, 3, VIEW_ACT, "R7 precharge before tRAS");  // c2
    issue(3'd7, 3, 1, 3, VIEW_ACT, "R9 code 7 on open");            // c3
    issue(CMD_PRE, 3, 1, 3, VIEW_PRC, "R7 precharge at tRAS");      // c4
    issue(CMD_ACT, 3, 0, 3, VIEW_PRC, "R2 activate precharging");   // c5
    issue(CMD_PRE, 3, 0, 3, VIEW_IDLE, "R7 precharge precharging"); // c6
    issue(CMD_NOP, 3, 1, 3, VIEW_IDLE, "R10 state after illegal");

    // R3: plain read keeps the row open
    issue(CMD_ACT, 2, 1, 2, VIEW_ACT, "R3 open b2");
    issue(CMD_RD, 2, 1, 2, VIEW_ACT, "R3 read open");
    nops(8);
    issue(CMD_RD, 2, 1, 2, VIEW_ACT, "R3 still open");
    issue(CMD_PRE, 2, 1, 2, VIEW_PRC, "R7 precharge open");
    nops(4);

    // R4: state timeline, start at cycle 5
    issue(CMD_ACT, 0, 1, 0, VIEW_ACT, "R4 act");       // c0
    issue(CMD_NOP, 0, 1, 0, VIEW_ACT, "R4 c1");
    issue(CMD_NOP, 0, 1, 0, VIEW_ACT, "R4 c2");
    issue(CMD_RDAP, 0, 1, 0, VIEW_ACT, "R4 ap-read");  // c3
    issue(CMD_NOP, 0, 1, 0, VIEW_ACT, "R4 c4");
    issue(CMD_NOP, 0, 1, 0, VIEW_PRC, "R4 c5 start");
    issue(CMD_NOP, 0, 1, 0, VIEW_PRC, "R4 c6");
    issue(CMD_NOP, 0, 1, 0, VIEW_IDLE, "R4 c7");
    nops(2);

    // R5: deferred start (ap-read at cycle 1, start at cycle 4)
    issue(CMD_ACT, 0, 1, 0, VIEW_ACT, "R5 act");                       // c0
    issue(CMD_RDAP, 0, 1, 0, VIEW_ACT, "R5 early ap-read");            // c1
    issue(CMD_NOP, 0, 1, 0, VIEW_ACT, "R5 c2");
    issue(CMD_PRE, 0, 0, 0, VIEW_ACT, "R10 refused precharge R7");     // c3
    issue(CMD_RD, 0, 1, 0, VIEW_PRC, "R5 deferred start R6 late read"); // c4
    issue(CMD_ACT, 0, 0, 0, VIEW_PRC, "R5 activate too soon");         // c5
    issue(CMD_ACT, 0, 0, 0, VIEW_IDLE, "R5 activate too soon");        // c6
    issue(CMD_ACT, 0, 1, 0, VIEW_ACT, "R5 activate after tRP");        // c7
    settle_all_idle("R5 cleanup idle");

    // Legality grid, same bank and other banks
    for (int k = 1; k <= 3; k++) run_grid(CMD_RD,   0, k, (k == 3) ? 1 : 0, "R6 same-bank read");
    for (int k = 1; k <= 3; k++) run_grid(CMD_RDAP, 0, k, (k == 3) ? 1 : 0, "R6 same-bank ap-read");
    for (int k = 1; k <= 5; k++) run_grid(CMD_ACT,  0, k, (k == 5) ? 1 : 0, "R4 same-bank activate");
    for (int k = 1; k <= 3; k++) run_grid(CMD_PRE,  0, k, (k == 3) ? 0 : 1, "R7 same-bank precharge");
    for (int k = 1; k <= 3; k++) run_grid(CMD_RD,   1, k, 1, "R8 other-bank read");
    for (int k = 1; k <= 3; k++) run_grid(CMD_RDAP, 1, k, 1, "R8 other-bank ap-read");
    for (int k = 1; k <= 3; k++) run_grid(CMD_ACT,  2, k, 1, "R8 other-bank activate");
    for (int k = 1; k <= 3; k++) run_grid(CMD_PRE,  1, k, 1, "R8 other-bank precharge");

    // R1: reset in the middle of activity
    issue(CMD_ACT, 1, 1, 1, VIEW_ACT, "R1 open before reset");
    nops(1);
    @(negedge clk);
    rst = 1'b1;
    cmd_i = CMD_NOP;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #(CLK_P/4);
    checks++;
    if (state_o !== 8'h00 || legal_o !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset: state_o=%h legal_o=%0b expected 00 1", state_o, legal_o);
    end
    issue(CMD_RD, 1, 0, 1, VIEW_IDLE, "R3 read after reset");
    nops(2);
    wait (q_el.size() == 0);
    @(posedge clk);
    #(CLK_P/4);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule